// File: doc/BRIEF.md
# Speculative Store Buffer with Forwarding

This block sits beside one thread processing element and collects every store that the element's speculative thread makes, so memory never sees a value the thread might later lose to a kill. Two kinds of store are held. A target store is one that later threads may depend on: it is first announced by address alone, as a placeholder, and later either filled with a value or released with none. A regular store is recorded with its value straight away. Placeholder, fill and release commands from the local thread are passed on to the successor element one cycle later, and the same three kinds of record arriving from predecessors are kept as remote entries.

A local load is looked up against every entry in the same cycle. The newest usable match either supplies its value, or, if it is a placeholder still waiting for data, tells the load to stall. A released placeholder counts as no match. With nothing usable, the load is reported as a miss and goes to memory. Nothing is guessed: a pending match always stalls.

When the thread is told it may commit, the buffer writes its own entries that hold values out to memory, one per cycle, oldest first, then pulses a done strobe and empties itself. A kill empties it in a single cycle.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the buffer is empty: a load misses, `full` is low, and `fwdOutValid` and `memWrValid` are low.
- R2: A local command with op 0 (placeholder) creates an address-only target entry; a load to that address then stalls.
- R3: A local command with op 1 (target value) fills the newest local target entry of that address (or creates a filled one if none exists); a later load to that address returns the value, and the record appears on the forward output one cycle after the command with kind 1, the address and the value.
- R4: Local op 0 and op 3 (release) are forwarded one cycle later with kind 0 and kind 3 and the command address; op 2 (regular store) is never forwarded.
- R5: Forwarded input kind 0 creates a remote placeholder (loads stall), kind 1 fills the newest remote target entry of that address or creates a filled one, and kind 3 releases a remote placeholder; kind 2 is ignored.
- R6: A release marks the newest unfilled local target entry of the address as resolved; loads then skip it and see an older match or miss.
- R7: When several usable entries match a load, the most recently allocated one decides the result.
- R8: A load with no usable match is reported as a miss with `ldData` zero; exactly one of hit, stall and miss is high while `ldValid` is high.
- R9: `full` is high exactly when DEPTH entries are held; further allocations are dropped, so a load to a dropped address misses.
- R10: A `wbStart` pulse drains the local entries holding values in allocation order, one per cycle, in consecutive cycles starting the cycle after the pulse; remote and valueless entries are skipped; `wbDone` pulses for one cycle in the cycle after the last write, and the buffer is then empty.
- R11: A `kill` pulse empties the buffer by the next cycle: loads miss and `full` is low.
- R12: `memWrValid` is never high outside a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Local store command present |
| cmdOp | input | 2 | 0 placeholder, 1 target value, 2 regular store, 3 release |
| cmdAddr | input | ADDR_W | Local command address |
| cmdData | input | DATA_W | Local command value |
| fwdInValid | input | 1 | Record from predecessor present |
| fwdInKind | input | 2 | 0 placeholder, 1 value, 3 release, 2 ignored |
| fwdInAddr | input | ADDR_W | Predecessor record address |
| fwdInData | input | DATA_W | Predecessor record value |
| fwdOutValid | output | 1 | Record to successor present |
| fwdOutKind | output | 2 | Kind of outgoing record (0, 1 or 3) |
| fwdOutAddr | output | ADDR_W | Outgoing record address |
| fwdOutData | output | DATA_W | Outgoing record value (zero unless kind 1) |
| ldValid | input | 1 | Local load lookup |
| ldAddr | input | ADDR_W | Load address |
| ldHit | output | 1 | Load served from buffer |
| ldStall | output | 1 | Load must wait for pending value |
| ldMiss | output | 1 | Load goes to memory |
| ldData | output | DATA_W | Value on hit, else zero |
| full | output | 1 | All entries in use |
| wbStart | input | 1 | Commit permission pulse |
| kill | input | 1 | Discard all entries |
| memWrValid | output | 1 | Write to memory this cycle |
| memWrAddr | output | ADDR_W | Memory write address |
| memWrData | output | DATA_W | Memory write value |
| wbDone | output | 1 | Write-back complete pulse |

## Verification
Loads are tried against a placeholder, a filled entry, a released placeholder sitting over an older regular store, stacked stores to one address, and a remote value created without a placeholder, which tells apart the newest-match rule from a first-match or a skip-nothing rule. A sweep fills the buffer to every level from empty to full with a mix of regular stores and placeholders, then drains it; the recorded write sequence and its cycle positions separate ordering, skipping of valueless entries and the done timing. A second sweep kills at every fill level, showing that clearing does not depend on how many entries exist, and the forward output is checked after each of the four local ops.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC   = 2'd0,
    OP_TDATA   = 2'd1,
    OP_RSTORE  = 2'd2,
    OP_RELEASE = 2'd3
  } opKind_e;

  typedef struct packed {
    logic valid;
    logic isTarget;
    logic isLocal;
    logic dataValid;
    logic released;
  } entryFlags_t;

  typedef struct packed {
    logic locAlloc;
    logic locFill;
    logic locStore;
    logic locRel;
    logic fwdAlloc;
    logic fwdFill;
    logic fwdRel;
    logic drainLoad;
    logic drainPop;
    logic clearAll;
  } ctrlStrobe_t;

endpackage

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic        fwdInValid,
  input  logic [1:0]  fwdInKind,
  input  logic        wbStart,
  input  logic        kill,
  input  logic        drainEmpty,
  output ctrlStrobe_t st,
  output logic        wbDone
);

  typedef enum logic {S_IDLE, S_DRAIN} state_e;
  state_e state, stateNext;
  logic   acceptCmd;

  always_comb begin
    st        = '0;
    wbDone    = 1'b0;
    stateNext = state;
    acceptCmd = !kill && (state == S_IDLE) && !wbStart;

    st.locAlloc = acceptCmd && cmdValid && (cmdOp == OP_ALLOC);
    st.locFill  = acceptCmd && cmdValid && (cmdOp == OP_TDATA);
    st.locStore = acceptCmd && cmdValid && (cmdOp == OP_RSTORE);
    st.locRel   = acceptCmd && cmdValid && (cmdOp == OP_RELEASE);
    st.fwdAlloc = acceptCmd && fwdInValid && (fwdInKind == OP_ALLOC);
    st.fwdFill  = acceptCmd && fwdInValid && (fwdInKind == OP_TDATA);
    st.fwdRel   = acceptCmd && fwdInValid && (fwdInKind == OP_RELEASE);

    if (kill) begin
      st.clearAll = 1'b1;
      stateNext   = S_IDLE;
    end else if (state == S_IDLE && wbStart) begin
      st.drainLoad = 1'b1;
      stateNext    = S_DRAIN;
    end else if (state == S_DRAIN) begin
      if (drainEmpty) begin
        wbDone      = 1'b1;
        st.clearAll = 1'b1;
        stateNext   = S_IDLE;
      end else begin
        st.drainPop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R10
  wb_done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbDone |=> !wbDone);

  // R10
  wb_start_chk: assert property (@(posedge clk) disable iff (!rstN || kill)
    (wbStart && state == S_IDLE) |=> (st.drainPop || wbDone));

endmodule

// File: rtl/ssb_dpath.sv
module ssb_dpath
  import ssb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       st,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] fwdInAddr,
  input  logic [DATA_W-1:0] fwdInData,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldHit,
  output logic              ldStall,
  output logic              ldMiss,
  output logic [DATA_W-1:0] ldData,
  output logic              full,
  output logic              drainEmpty,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              fwdOutValid,
  output logic [1:0]        fwdOutKind,
  output logic [ADDR_W-1:0] fwdOutAddr,
  output logic [DATA_W-1:0] fwdOutData
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  entryFlags_t       flags [DEPTH];
  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [CW-1:0]     count;
  logic [DEPTH-1:0]  drainMask;

  logic [DEPTH-1:0] locTgtHit, locRelHit, remTgtHit, remRelHit, ldElig, drainCand;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign locTgtHit[i] = flags[i].valid && flags[i].isTarget && flags[i].isLocal
                          && (addrQ[i] == cmdAddr);
    assign locRelHit[i] = locTgtHit[i] && !flags[i].dataValid;
    assign remTgtHit[i] = flags[i].valid && flags[i].isTarget && !flags[i].isLocal
                          && (addrQ[i] == fwdInAddr);
    assign remRelHit[i] = remTgtHit[i] && !flags[i].dataValid;
    assign ldElig[i]    = flags[i].valid && (addrQ[i] == ldAddr)
                          && !(flags[i].released && !flags[i].dataValid);
    assign drainCand[i] = flags[i].valid && flags[i].isLocal && flags[i].dataValid;
  end

  function automatic logic [IW:0] pickNewest(input logic [DEPTH-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int k = 0; k < DEPTH; k++) if (v[k]) r = {1'b1, IW'(k)};
    return r;
  endfunction

  function automatic logic [IW:0] pickOldest(input logic [DEPTH-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int k = DEPTH - 1; k >= 0; k--) if (v[k]) r = {1'b1, IW'(k)};
    return r;
  endfunction

  logic          locFillAny, locRelAny, remFillAny, remRelAny, ldAny, drainAny;
  logic [IW-1:0] locFillIdx, locRelIdx, remFillIdx, remRelIdx, ldSel, drainIdx;

  assign {locFillAny, locFillIdx} = pickNewest(locTgtHit);
  assign {locRelAny,  locRelIdx}  = pickNewest(locRelHit);
  assign {remFillAny, remFillIdx} = pickNewest(remTgtHit);
  assign {remRelAny,  remRelIdx}  = pickNewest(remRelHit);
  assign {ldAny,      ldSel}      = pickNewest(ldElig);
  assign {drainAny,   drainIdx}   = pickOldest(drainMask);

  // slot allocation: forwarded record first, local command in the next slot
  logic          fwdNeed, fwdGets, locNeed, locGets;
  logic [CW-1:0] locSlotC;
  logic [IW-1:0] fwdSlot, locSlot;

  assign fwdNeed  = st.fwdAlloc || (st.fwdFill && !remFillAny);
  assign fwdGets  = fwdNeed && (count < DEPTH_C);
  assign locNeed  = st.locAlloc || st.locStore || (st.locFill && !locFillAny);
  assign locSlotC = count + CW'(fwdGets);
  assign locGets  = locNeed && (locSlotC < DEPTH_C);
  assign fwdSlot  = IW'(count);
  assign locSlot  = IW'(locSlotC);

  always_ff @(posedge clk) begin
    if (!rstN || st.clearAll) begin
      for (int k = 0; k < DEPTH; k++) flags[k] <= '0;
      count     <= '0;
      drainMask <= '0;
    end else begin
      if (st.locFill && locFillAny) begin
        flags[locFillIdx].dataValid <= 1'b1;
        flags[locFillIdx].released  <= 1'b0;
      end
      if (st.locRel && locRelAny) flags[locRelIdx].released <= 1'b1;
      if (st.fwdFill && remFillAny) begin
        flags[remFillIdx].dataValid <= 1'b1;
        flags[remFillIdx].released  <= 1'b0;
      end
      if (st.fwdRel && remRelAny) flags[remRelIdx].released <= 1'b1;
      if (fwdGets)
        flags[fwdSlot] <= '{valid: 1'b1, isTarget: 1'b1, isLocal: 1'b0,
                            dataValid: st.fwdFill, released: 1'b0};
      if (locGets)
        flags[locSlot] <= '{valid: 1'b1, isTarget: !st.locStore, isLocal: 1'b1,
                            dataValid: st.locFill || st.locStore, released: 1'b0};
      count <= count + CW'(fwdGets) + CW'(locGets);
      if (st.drainLoad)    drainMask <= drainCand;
      else if (st.drainPop) drainMask[drainIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (st.locFill && locFillAny) dataQ[locFillIdx] <= cmdData;
    if (st.fwdFill && remFillAny) dataQ[remFillIdx] <= fwdInData;
    if (fwdGets) begin
      addrQ[fwdSlot] <= fwdInAddr;
      dataQ[fwdSlot] <= fwdInData;
    end
    if (locGets) begin
      addrQ[locSlot] <= cmdAddr;
      dataQ[locSlot] <= cmdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdOutValid <= 1'b0;
      fwdOutKind  <= 2'd0;
      fwdOutAddr  <= '0;
      fwdOutData  <= '0;
    end else begin
      fwdOutValid <= st.locAlloc || st.locFill || st.locRel;
      fwdOutKind  <= st.locAlloc ? OP_ALLOC : (st.locFill ? OP_TDATA : OP_RELEASE);
      fwdOutAddr  <= cmdAddr;
      fwdOutData  <= st.locFill ? cmdData : '0;
    end
  end

  assign ldHit      = ldValid && ldAny && flags[ldSel].dataValid;
  assign ldStall    = ldValid && ldAny && !flags[ldSel].dataValid;
  assign ldMiss     = ldValid && !ldAny;
  assign ldData     = ldHit ? dataQ[ldSel] : '0;
  assign full       = (count == DEPTH_C);
  assign drainEmpty = (drainMask == '0);
  assign memWrValid = st.drainPop && drainAny;
  assign memWrAddr  = addrQ[drainIdx];
  assign memWrData  = dataQ[drainIdx];

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);

  // R8
  ld_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |-> ($countones({ldHit, ldStall, ldMiss}) == 1));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.clearAll |=> (count == '0 && drainEmpty));

  // R10
  drain_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.drainPop |-> (flags[drainIdx].valid && flags[drainIdx].isLocal
                     && flags[drainIdx].dataValid));

  // R3
  fwd_out_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.locFill |=> (fwdOutValid && fwdOutKind == OP_TDATA));

endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
  import ssb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              fwdInValid,
  input  logic [1:0]        fwdInKind,
  input  logic [ADDR_W-1:0] fwdInAddr,
  input  logic [DATA_W-1:0] fwdInData,
  output logic              fwdOutValid,
  output logic [1:0]        fwdOutKind,
  output logic [ADDR_W-1:0] fwdOutAddr,
  output logic [DATA_W-1:0] fwdOutData,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldHit,
  output logic              ldStall,
  output logic              ldMiss,
  output logic [DATA_W-1:0] ldData,
  output logic              full,
  input  logic              wbStart,
  input  logic              kill,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              wbDone
);

  ctrlStrobe_t strobes;
  logic        drainEmpty;

  ssb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .fwdInValid (fwdInValid),
    .fwdInKind  (fwdInKind),
    .wbStart    (wbStart),
    .kill       (kill),
    .drainEmpty (drainEmpty),
    .st         (strobes),
    .wbDone     (wbDone)
  );

  ssb_dpath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (strobes),
    .cmdAddr     (cmdAddr),
    .cmdData     (cmdData),
    .fwdInAddr   (fwdInAddr),
    .fwdInData   (fwdInData),
    .ldValid     (ldValid),
    .ldAddr      (ldAddr),
    .ldHit       (ldHit),
    .ldStall     (ldStall),
    .ldMiss      (ldMiss),
    .ldData      (ldData),
    .full        (full),
    .drainEmpty  (drainEmpty),
    .memWrValid  (memWrValid),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .fwdOutValid (fwdOutValid),
    .fwdOutKind  (fwdOutKind),
    .fwdOutAddr  (fwdOutAddr),
    .fwdOutData  (fwdOutData)
  );

  // R12
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> !wbStart);

endmodule

// File: tb/tb_spec_store_buf.sv
`timescale 1ns/1ps
module tb_spec_store_buf;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [31:0] cmdAddr = '0, cmdData = '0;
  logic        fwdInValid = 1'b0;
  logic [1:0]  fwdInKind = 2'd0;
  logic [31:0] fwdInAddr = '0, fwdInData = '0;
  logic        fwdOutValid;
  logic [1:0]  fwdOutKind;
  logic [31:0] fwdOutAddr, fwdOutData;
  logic        ldValid = 1'b0;
  logic [31:0] ldAddr = '0;
  logic        ldHit, ldStall, ldMiss;
  logic [31:0] ldData;
  logic        full;
  logic        wbStart = 1'b0, kill = 1'b0;
  logic        memWrValid;
  logic [31:0] memWrAddr, memWrData;
  logic        wbDone;

  int checks = 0;
  int errors = 0;
  int stray  = 0;
  bit inWb   = 1'b0;
  logic [31:0] expA [DEPTH];
  logic [31:0] expD [DEPTH];
  int expN;

  always #2.5 clk = ~clk;

  spec_store_buf #(.DEPTH(DEPTH), .ADDR_W(32), .DATA_W(32)) dut (.*);

  always @(negedge clk) if (rstN && memWrValid && !inWb) stray++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doFwd(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    fwdInValid = 1'b1; fwdInKind = k; fwdInAddr = a; fwdInData = d;
    @(negedge clk);
    fwdInValid = 1'b0;
  endtask

  // kind: 0 hit, 1 stall, 2 miss
  task automatic ldChk(input logic [31:0] a, input int kind, input logic [31:0] d,
                       input string req);
    logic [2:0] expV;
    expV = (kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001;
    ldValid = 1'b1; ldAddr = a;
    #1;
    chk({ldHit, ldStall, ldMiss} == expV, req, "load result", {ldHit, ldStall, ldMiss}, expV);
    if (kind == 0) chk(ldData == d, req, "load data", ldData, d);
    if (kind == 2) chk(ldData == 32'd0, req, "miss data", ldData, 0);
    ldValid = 1'b0;
  endtask

  task automatic fwdOutChk(input bit v, input logic [1:0] k, input logic [31:0] a,
                           input logic [31:0] d, input string req);
    chk(fwdOutValid == v, req, "fwdOutValid", fwdOutValid, v);
    if (v) begin
      chk(fwdOutKind == k, req, "fwdOutKind", fwdOutKind, k);
      chk(fwdOutAddr == a, req, "fwdOutAddr", fwdOutAddr, a);
      chk(fwdOutData == d, req, "fwdOutData", fwdOutData, d);
    end
  endtask

  task automatic runDrain(input string req);
    int idx;
    bit done;
    idx = 0; done = 1'b0;
    inWb = 1'b1;
    @(negedge clk); wbStart = 1'b1;
    @(negedge clk); wbStart = 1'b0;
    for (int cyc = 1; cyc <= 2 * DEPTH + 4; cyc++) begin
      if (memWrValid) begin
        chk(idx < expN, req, "extra write", idx, expN);
        if (idx < expN) begin
          chk(memWrAddr == expA[idx], req, "drain addr", memWrAddr, expA[idx]);
          chk(memWrData == expD[idx], req, "drain data", memWrData, expD[idx]);
          chk(cyc == idx + 1, req, "drain cycle", cyc, idx + 1);
        end
        idx++;
      end
      if (wbDone) begin
        chk(cyc == expN + 1, req, "done cycle", cyc, expN + 1);
        done = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk(done && idx == expN, req, "writes before done", idx, expN);
    @(negedge clk);
    chk(wbDone == 1'b0, req, "done is a pulse", wbDone, 0);
    inWb = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(full == 1'b0, "R1", "full", full, 0);
    chk(fwdOutValid == 1'b0, "R1", "fwdOutValid", fwdOutValid, 0);
    chk(memWrValid == 1'b0, "R1", "memWrValid", memWrValid, 0);
    ldChk(32'h100, 2, 0, "R1");

    // R2 R4 placeholder
    doCmd(2'd0, 32'h100, 32'h0);
    fwdOutChk(1'b1, 2'd0, 32'h100, 32'h0, "R4");
    ldChk(32'h100, 1, 0, "R2");

    // R3 fill
    doCmd(2'd1, 32'h100, 32'hAAAA);
    fwdOutChk(1'b1, 2'd1, 32'h100, 32'hAAAA, "R3");
    ldChk(32'h100, 0, 32'hAAAA, "R3");

    // R8 miss
    ldChk(32'h200, 2, 0, "R8");

    // R4 regular store not forwarded
    doCmd(2'd2, 32'h300, 32'd5);
    fwdOutChk(1'b0, 2'd0, 0, 0, "R4");
    ldChk(32'h300, 0, 32'd5, "R4");

    // R7 newer placeholder over older store, R6 release
    doCmd(2'd0, 32'h300, 32'h0);
    ldChk(32'h300, 1, 0, "R7");
    doCmd(2'd3, 32'h300, 32'h0);
    fwdOutChk(1'b1, 2'd3, 32'h300, 32'h0, "R4");
    ldChk(32'h300, 0, 32'd5, "R6");

    // R5 forwarded records
    doFwd(2'd0, 32'h400, 32'h0);
    ldChk(32'h400, 1, 0, "R5");
    doFwd(2'd1, 32'h400, 32'h77);
    ldChk(32'h400, 0, 32'h77, "R5");
    doFwd(2'd2, 32'h480, 32'h99);
    ldChk(32'h480, 2, 0, "R5");
    doFwd(2'd0, 32'h500, 32'h0);
    ldChk(32'h500, 1, 0, "R5");
    doFwd(2'd3, 32'h500, 32'h0);
    ldChk(32'h500, 2, 0, "R5");

    // R7 stacked stores, remote value without placeholder
    doCmd(2'd2, 32'h600, 32'd1);
    doCmd(2'd2, 32'h600, 32'd2);
    ldChk(32'h600, 0, 32'd2, "R7");
    chk(full == 1'b0, "R9", "full at 7", full, 0);
    doFwd(2'd1, 32'h600, 32'd3);
    ldChk(32'h600, 0, 32'd3, "R7");

    // R9 full, dropped allocation
    chk(full == 1'b1, "R9", "full at 8", full, 1);
    doCmd(2'd2, 32'h700, 32'd9);
    ldChk(32'h700, 2, 0, "R9");

    // R10 drain of mixed contents
    expN = 4;
    expA[0] = 32'h100; expD[0] = 32'hAAAA;
    expA[1] = 32'h300; expD[1] = 32'd5;
    expA[2] = 32'h600; expD[2] = 32'd1;
    expA[3] = 32'h600; expD[3] = 32'd2;
    runDrain("R10");
    ldChk(32'h100, 2, 0, "R10");
    chk(full == 1'b0, "R10", "full after drain", full, 0);

    // R9 R10 sweep over fill levels
    for (int k = 0; k <= DEPTH; k++) begin
      expN = 0;
      for (int i = 0; i < k; i++) begin
        if (i % 3 == 2) doCmd(2'd0, 32'h1000 + 4 * i, 32'h0);
        else begin
          doCmd(2'd2, 32'h1000 + 4 * i, 32'h100 * i + 7);
          expA[expN] = 32'h1000 + 4 * i;
          expD[expN] = 32'h100 * i + 7;
          expN++;
        end
      end
      chk(full == (k == DEPTH), "R9", "full in sweep", full, (k == DEPTH));
      runDrain("R10");
      ldChk(32'h1000, 2, 0, "R10");
    end

    // R11 kill at every level
    for (int k = 1; k <= DEPTH; k++) begin
      for (int i = 0; i < k; i++) doCmd(2'd2, 32'h2000 + 4 * i, i + 1);
      @(negedge clk); kill = 1'b1;
      @(negedge clk); kill = 1'b0;
      chk(full == 1'b0, "R11", "full after kill", full, 0);
      for (int i = 0; i < k; i++) ldChk(32'h2000 + 4 * i, 2, 0, "R11");
    end
    expN = 0;
    runDrain("R11");

    // R12 no write outside write-back
    chk(stray == 0, "R12", "stray writes", stray, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule